// File: doc/BRIEF.md
# Daisy-Chained Volume Address Appointment

This block holds the per-package logic that lets several flash packages share one chip-enable line. The packages form a chain. Each package passes a ready signal to the next one, and the ready signal of the first package is tied high. When the host issues an "assign" command on the shared command bus, it is taken only by the one package that is ready and does not hold an address yet. That package stores the address from the command. One cycle later it raises its ready signal toward the next package, so the next assign command goes to the next package.

Once every package holds its own address, the host picks a package with a "select" command that carries an address. A package that holds an address raises its selected flag when its stored address equals the command address, and clears the flag otherwise. The top level instantiates `N_PKG` copies in a chain. It exposes each package's ready signal, stored address and selected flag so the chain can be watched at the ports.

Top module: `vol_chain`

## Requirements
- R1: While `rst_ni` is low, every `en_o` bit, every `sel_o` bit and all of `addr_o` are zero.
- R2: The op field `cmd_op_i` is taken only when `cmd_valid_i` is high. The value 2'b01 means assign. An accepted assign stores `cmd_addr_i` into the package that takes it, in slice `addr_o[i*ADDR_W +: ADDR_W]` for package i, on the same clock edge.
- R3: A package's `en_o` bit rises on the clock edge that follows the edge at which it accepted its assign. At the edge of acceptance itself it is still low.
- R4: A package whose incoming ready signal is low ignores assign. Two assign commands in consecutive cycles therefore store only the first one.
- R5: A package that already holds an address ignores later assign commands. Its stored address never changes until reset.
- R6: N assign commands, each followed by one idle cycle, store N addresses in chain order, from package 0 to package N-1, and leave all `en_o` bits high.
- R7: An assign command issued after the last package is filled changes no output.
- R8: The value 2'b10 of `cmd_op_i` means select. On the next edge, each package that holds an address sets its `sel_o` bit if its stored address equals `cmd_addr_i` and clears it otherwise.
- R9: A select whose address matches no stored address clears every `sel_o` bit.
- R10: A package without an address never sets `sel_o`, even if the command address equals its reset value of zero.
- R11: The op values 2'b00 and 2'b11 change no output, and neither does any cycle with `cmd_valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe for one cycle |
| cmd_op_i | input | 2 | Op code: 01 assign, 10 select, 00/11 no operation |
| cmd_addr_i | input | ADDR_W | Volume address carried by the command |
| en_o | output | N_PKG | Ready signal each package passes down the chain |
| addr_o | output | N_PKG*ADDR_W | Stored address of each package, package i in slice i |
| sel_o | output | N_PKG | Selected flag of each package |

## Verification
If a package latched the wrong assignment, the mistake shows in its `addr_o` slice at the edge that accepts the command. If its ready flag were wrong, `en_o` would be off one edge later, and the next package would then take or miss the following assign. A wrong stored address or a wrong ready state also shows on the first select that follows, because `sel_o` settles one edge after that command. The bench therefore checks the outputs after every command, so any fault surfaces within two cycles of the command that exposes it.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_NOP = 2'b00,
    VC_SET = 2'b01,
    VC_SEL = 2'b10,
    VC_RSV = 2'b11
  } vc_op_e;
endpackage

// File: rtl/vc_cmd_decode.sv
module vc_cmd_decode
  import vc_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  output logic       set_stb_o,
  output logic       sel_stb_o
);
  always_comb begin
    set_stb_o = 1'b0;
    sel_stb_o = 1'b0;
    if (valid_i) begin
      unique case (vc_op_e'(op_i))
        VC_SET:  set_stb_o = 1'b1;
        VC_SEL:  sel_stb_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vc_node.sv
module vc_node #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              set_stb_i,
  input  logic              sel_stb_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o
);
  logic              assigned_q;
  logic [ADDR_W-1:0] addr_q;
  logic              en_q;
  logic              sel_q;
  logic              take;

  assign take = set_stb_i && en_i && !assigned_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      assigned_q <= 1'b0;
      addr_q     <= '0;
      en_q       <= 1'b0;
      sel_q      <= 1'b0;
    end else begin
      if (take) begin
        addr_q     <= cmd_addr_i;
        assigned_q <= 1'b1;
      end
      // ready to successor trails the latch by one edge
      en_q <= assigned_q;
      if (sel_stb_i) sel_q <= assigned_q && (addr_q == cmd_addr_i);
    end
  end

  assign en_o   = en_q;
  assign addr_o = addr_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/vol_chain.sv
module vol_chain #(
  parameter int unsigned N_PKG  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [1:0]              cmd_op_i,
  input  logic [ADDR_W-1:0]       cmd_addr_i,
  output logic [N_PKG-1:0]        en_o,
  output logic [N_PKG*ADDR_W-1:0] addr_o,
  output logic [N_PKG-1:0]        sel_o
);
  logic             set_stb;
  logic             sel_stb;
  logic [N_PKG:0]   chain;

  vc_cmd_decode u_dec (
    .valid_i   (cmd_valid_i),
    .op_i      (cmd_op_i),
    .set_stb_o (set_stb),
    .sel_stb_o (sel_stb)
  );

  assign chain[0] = 1'b1;

  for (genvar i = 0; i < N_PKG; i++) begin : g_node
    vc_node #(.ADDR_W(ADDR_W)) u_node (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (chain[i]),
      .set_stb_i  (set_stb),
      .sel_stb_i  (sel_stb),
      .cmd_addr_i (cmd_addr_i),
      .en_o       (chain[i+1]),
      .addr_o     (addr_o[i*ADDR_W +: ADDR_W]),
      .sel_o      (sel_o[i])
    );
  end

  assign en_o = chain[N_PKG:1];
endmodule

// File: rtl/vol_chain_chk.sv
module vol_chain_chk
  import vc_pkg::*;
#(
  parameter int unsigned N_PKG  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cmd_valid_i,
  input logic [1:0]              cmd_op_i,
  input logic [ADDR_W-1:0]       cmd_addr_i,
  input logic [N_PKG-1:0]        en_o,
  input logic [N_PKG*ADDR_W-1:0] addr_o,
  input logic [N_PKG-1:0]        sel_o
);
  for (genvar i = 0; i < N_PKG; i++) begin : g_chk
    // R5: ready is sticky and the address is frozen once ready is high
    a_r5_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[i] |=> en_o[i]);
    a_r5_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[i] |=> $stable(addr_o[i*ADDR_W +: ADDR_W]));
    // R3: ready rises two edges after an assign was presented
    a_r3_ready_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_o[i]) |-> $past(cmd_valid_i && cmd_op_i == VC_SET, 2));
    // R10: no selection without a held address
    a_r10_sel_needs_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_o[i] |-> en_o[i]);
    // R8: a matching select on a ready package selects it
    a_r8_match_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && cmd_op_i == VC_SEL && en_o[i] &&
       addr_o[i*ADDR_W +: ADDR_W] == cmd_addr_i) |=> sel_o[i]);
    if (i > 0) begin : g_order
      // R6: chain fills in order
      a_r6_chain_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_o[i] |-> en_o[i-1]);
    end
  end

  // R11: idle bus leaves addresses and selections alone
  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> ($stable(sel_o) && $stable(addr_o)));
endmodule

bind vol_chain vol_chain_chk #(.N_PKG(N_PKG), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_addr_i  (cmd_addr_i),
  .en_o        (en_o),
  .addr_o      (addr_o),
  .sel_o       (sel_o)
);

// File: tb/vol_chain_tb.sv
module vol_chain_tb;
  localparam int N_PKG  = 4;
  localparam int ADDR_W = 4;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    cmd_valid;
  logic [1:0]              cmd_op;
  logic [ADDR_W-1:0]       cmd_addr;
  logic [N_PKG-1:0]        en;
  logic [N_PKG*ADDR_W-1:0] addr;
  logic [N_PKG-1:0]        sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vol_chain #(.N_PKG(N_PKG), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .en_o(en), .addr_o(addr), .sel_o(sel)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [1:0]  op;
    logic [3:0]  a;
    logic [15:0] x_addr;
    logic [3:0]  x_en;
    logic [3:0]  x_sel;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{"R2 ", 2'b01, 4'hA, 16'h000A, 4'b0001, 4'b0000},
    '{"R6 ", 2'b01, 4'h3, 16'h003A, 4'b0011, 4'b0000},
    '{"R6 ", 2'b01, 4'h7, 16'h073A, 4'b0111, 4'b0000},
    '{"R6 ", 2'b01, 4'hC, 16'hC73A, 4'b1111, 4'b0000},
    '{"R7 ", 2'b01, 4'h5, 16'hC73A, 4'b1111, 4'b0000},
    '{"R8 ", 2'b10, 4'h7, 16'hC73A, 4'b1111, 4'b0100},
    '{"R8 ", 2'b10, 4'hA, 16'hC73A, 4'b1111, 4'b0001},
    '{"R9 ", 2'b10, 4'h5, 16'hC73A, 4'b1111, 4'b0000},
    '{"R11", 2'b11, 4'hC, 16'hC73A, 4'b1111, 4'b0000},
    '{"R8 ", 2'b10, 4'hC, 16'hC73A, 4'b1111, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive a command for one edge, leave the bus idle at the next negedge
  task automatic issue(input logic v, input logic [1:0] op, input logic [3:0] a);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 en", 32'(en), 32'h0);
    chk("R1 sel", 32'(sel), 32'h0);
    chk("R1 addr", 32'(addr), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 en", 32'(en), 32'h0);
    chk("R1 addr", 32'(addr), 32'h0);

    // table walk: command, one idle edge, then compare
    foreach (VEC[k]) begin
      issue(1'b1, VEC[k].op, VEC[k].a);
      @(negedge clk);
      chk({string'(VEC[k].tag), " addr"}, 32'(addr), 32'(VEC[k].x_addr));
      chk({string'(VEC[k].tag), " en"},   32'(en),   32'(VEC[k].x_en));
      chk({string'(VEC[k].tag), " sel"},  32'(sel),  32'(VEC[k].x_sel));
    end

    // R1 reset mid-run clears everything
    do_reset();

    // R3 / R4 back-to-back assigns
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 4'h1;
    @(negedge clk);
    chk("R2 addr latched at accept edge", 32'(addr), 32'h0001);
    chk("R3 en low at accept edge", 32'(en), 32'h0);
    cmd_addr = 4'h2;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0;
    chk("R3 en high one edge later", 32'(en), 32'h1);
    chk("R4 second back-to-back assign dropped", 32'(addr), 32'h0001);
    @(negedge clk);
    chk("R4 successor still empty", 32'(en), 32'h1);

    // R10 select address zero while packages 1..3 are empty
    issue(1'b1, 2'b10, 4'h0);
    chk("R10 empty package not selected", 32'(sel), 32'h0);

    // R11 valid low with assign op
    issue(1'b0, 2'b01, 4'h9);
    @(negedge clk);
    chk("R11 invalid cycle ignored", 32'(addr), 32'h0001);
    chk("R11 en unchanged", 32'(en), 32'h1);

    // R5 filled package ignores, successor takes it
    issue(1'b1, 2'b01, 4'h9);
    @(negedge clk);
    chk("R5 package0 keeps address", 32'(addr), 32'h0091);
    chk("R5 en", 32'(en), 32'h3);

    // R8 select then R11 nop keeps selection
    issue(1'b1, 2'b10, 4'h1);
    chk("R8 select package0", 32'(sel), 32'h1);
    issue(1'b1, 2'b00, 4'h9);
    chk("R11 nop keeps selection", 32'(sel), 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule